// File: doc/BRIEF.md
# Banked Prioritized Interrupt Controller

This block collects interrupt requests from a parameterized number of banks, each of 32 lines, and presents them to a processor on two outputs: a normal interrupt and a fast interrupt. Each line has its own control word. The word chooses edge or level sensitivity, chooses which output the line is routed to, and sets a 5-bit priority. A per-bank mask register gates each line. A pending register records latched requests. Software can read the pending register, clear bits in it, and raise a line through a software-set register.

When an output is armed and at least one line is eligible for it, the controller picks a winner. The winner is the lowest priority value, and on a tie the highest global line number. The controller stores the winner in that output's source-code register and drives the output high. The output then stays high with that snapshot frozen until software writes the matching control bit, which re-arms it. Reading a source-code register returns the winner's line number within its bank, and also retires the winner if it is edge type.

Access is through a simple strobed register port: a byte address, write data, a write strobe, a read strobe and combinational read data. A read or write takes effect on the clock edge that samples the strobe.

Top module: `bic_top`

## Requirements
- R1: After reset every mask register reads all ones, every pending register and every line control word reads zero, both outputs are low, and both outputs are armed.
- R2: Address bits [ADDR_W-1:8] select the bank and bits [7:0] the offset. The offsets are: pending 0x00, mask 0x04, normal source code 0x10, fast source code 0x14, control 0x18, line n control word 0x1C+4*n, software-set 0x9C. Any other offset, the software-set register and the control register all read as zero.
- R3: A line control word packs the priority in bits [6:2], the sensitivity in bit 1 (1 = level, 0 = edge) and the route in bit 0 (1 = fast output, 0 = normal output). A read returns the same packing, with the upper bits zero.
- R4: An edge-type line becomes pending on the clock edge after its input goes from 0 to 1. It stays pending when the input falls. An input held high does not set the line again.
- R5: A level-type line is pending while its input is high. Its pending bit clears on the clock edge after the input goes low.
- R6: A write to the pending register ANDs each bit with the written value. A level-type line whose input is high keeps its pending bit.
- R7: A line is eligible for an output when it is pending, its mask bit is 0, and its route bit selects that output. An armed output goes high on the clock edge after an eligible line appears. Masked lines never fire.
- R8: The winner is the eligible line with the smallest priority value. Among equal priorities, the largest global number (bank*32+line) wins.
- R9: Once high, an output stays high and its source code stays frozen until a control write in bank 0. Control bit 0 serves the normal output and bit 1 the fast output. The write drives that output low and re-arms it, and a new winner is taken on the following edge.
- R10: A source-code read returns the captured winner's line number within its bank, in bits [4:0]. If the winner is edge type, the read also clears its pending bit. A level-type winner keeps its pending bit.
- R11: A write to the software-set register makes only the lowest-numbered set bit of the written value pending in that bank.
- R12: A source-code read before any capture returns 0 and clears nothing. A control write in a bank other than 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NBANKS*32 | Request inputs, global line number = bank*32+line |
| addr | input | ADDR_W | Register byte address, bank in the upper bits |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; a source-code read has its side effect on this edge |
| rdata | output | 32 | Read data, valid while rd_en is high, zero otherwise |
| irq_norm_o | output | 1 | Normal processor interrupt |
| irq_fast_o | output | 1 | Fast processor interrupt |

## Verification
The bench targets priority ties that span both banks. A design that broke ties toward the lower line number, or only within a bank, would report the wrong source code. It checks that a clearing write cannot remove a level request whose input is still high, and that an edge request survives its input falling; swapping the two sensitivity rules would show up there. It checks that a new, more urgent request arriving while an output is high leaves the frozen code alone, and that a control write to a bank other than 0 does not re-arm. A design that re-evaluated continuously, or decoded the control register in every bank, would fail those checks. Random trials mix masks, routes and tied priorities across all lines, and compare both source codes with a model computed in the bench.

// File: rtl/bic_pkg.sv
package bic_pkg;

    localparam int LINES_PER_BANK = 32;
    localparam int PRIO_W         = 5;
    localparam int DATA_W         = 32;

    // Register offsets inside a bank window
    localparam logic [7:0] OFF_PEND   = 8'h00;
    localparam logic [7:0] OFF_MASK   = 8'h04;
    localparam logic [7:0] OFF_CODE_N = 8'h10;
    localparam logic [7:0] OFF_CODE_F = 8'h14;
    localparam logic [7:0] OFF_CTRL   = 8'h18;
    localparam logic [7:0] OFF_LINE0  = 8'h1C;
    localparam logic [7:0] OFF_LINEN  = 8'h98;
    localparam logic [7:0] OFF_SWSET  = 8'h9C;

    // Per-line control word, packed as priority | level | fast
    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic              level;
        logic              fast;
    } line_cfg_t;

    localparam int CFG_W = $bits(line_cfg_t);

    // Per-output agreement state
    typedef struct packed {
        logic armed;   // waiting for a new winner
        logic active;  // output driven high
        logic seen;    // a winner was captured at least once
    } agr_t;

    function automatic logic [DATA_W-1:0] pack_cfg(input line_cfg_t c);
        return {{(DATA_W-CFG_W){1'b0}}, c};
    endfunction

    function automatic line_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
        return line_cfg_t'(w);
    endfunction

    function automatic logic [DATA_W-1:0] lowest_bit(input logic [DATA_W-1:0] v);
        return v & (~v + {{(DATA_W-1){1'b0}}, 1'b1});
    endfunction

    function automatic logic is_line_off(input logic [7:0] off);
        return (off >= OFF_LINE0) && (off <= OFF_LINEN) && (off[1:0] == 2'b00);
    endfunction

    function automatic logic [4:0] line_of(input logic [7:0] off);
        logic [7:0] d;
        d = off - OFF_LINE0;
        return d[6:2];
    endfunction

endpackage

// File: rtl/bic_bank.sv
module bic_bank
    import bic_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic [LINES_PER_BANK-1:0]        irq_in,
    input  logic                             wr_en,
    input  logic [7:0]                       off,
    input  logic [DATA_W-1:0]                wdata,
    input  logic [LINES_PER_BANK-1:0]        clr_vec,
    output logic [LINES_PER_BANK-1:0]        pend,
    output logic [LINES_PER_BANK-1:0]        mask,
    output logic [LINES_PER_BANK-1:0]        fast,
    output logic [LINES_PER_BANK*PRIO_W-1:0] prio_flat,
    output logic [DATA_W-1:0]                rdata_loc
);

    line_cfg_t                  cfg_q [LINES_PER_BANK];
    logic [LINES_PER_BANK-1:0]  pend_q, mask_q, in_q;
    logic [LINES_PER_BANK-1:0]  level_v, sw_vec, rise, set_vec, keep, wr_keep;
    logic                       wr_pend, wr_mask, wr_sw, wr_line;
    logic [4:0]                 line_idx;

    genvar g;
    generate
        for (g = 0; g < LINES_PER_BANK; g++) begin : gen_cfg
            assign level_v[g] = cfg_q[g].level;
            assign fast[g]    = cfg_q[g].fast;
            assign prio_flat[g*PRIO_W +: PRIO_W] = cfg_q[g].prio;
        end
    endgenerate

    assign wr_pend  = wr_en && (off == OFF_PEND);
    assign wr_mask  = wr_en && (off == OFF_MASK);
    assign wr_sw    = wr_en && (off == OFF_SWSET);
    assign wr_line  = wr_en && is_line_off(off);
    assign line_idx = line_of(off);

    assign sw_vec  = wr_sw ? lowest_bit(wdata) : '0;
    assign rise    = irq_in & ~in_q;
    // New requests: edge lines on a rising input, level lines while high
    assign set_vec = (rise & ~level_v) | (irq_in & level_v) | sw_vec;
    // Level lines with a live input survive a clearing write
    assign wr_keep = wr_pend ? (wdata | (irq_in & level_v)) : '1;
    assign keep    = ~(level_v & ~irq_in) & ~(clr_vec & ~level_v) & wr_keep;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            mask_q <= '1;
            in_q   <= '0;
            for (int i = 0; i < LINES_PER_BANK; i++) cfg_q[i] <= '0;
        end else begin
            in_q   <= irq_in;
            pend_q <= (pend_q & keep) | set_vec;
            if (wr_mask) mask_q <= wdata;
            if (wr_line) cfg_q[line_idx] <= unpack_cfg(wdata[CFG_W-1:0]);
        end
    end

    assign pend = pend_q;
    assign mask = mask_q;

    always_comb begin
        rdata_loc = '0;
        if (off == OFF_PEND)       rdata_loc = pend_q;
        else if (off == OFF_MASK)  rdata_loc = mask_q;
        else if (is_line_off(off)) rdata_loc = pack_cfg(cfg_q[line_idx]);
    end

    // R5: a level line whose input was low (and not software-raised) is not pending next cycle
    a_r5_level_drop: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & $past(level_v & ~irq_in & ~sw_vec)) == '0));

    // R4: an edge pending bit survives unless written or retired by a code read
    a_r4_edge_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_pend |=> (($past(pend_q & ~level_v & ~clr_vec) & ~pend_q) == '0));

    // R6: a clearing write leaves live level lines pending
    a_r6_level_keep: assert property (@(posedge clk) disable iff (rst)
        wr_pend |=> ((~pend_q & $past(irq_in & level_v)) == '0));

    // R11: a software-set write raises at most one new line
    a_r11_one_line: assert property (@(posedge clk) disable iff (rst)
        wr_sw |-> $onehot0(sw_vec));

endmodule

// File: rtl/bic_arbiter.sv
module bic_arbiter #(
    parameter int N  = 64,
    parameter int PW = 5,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    elig,
    input  logic [N*PW-1:0] prio_flat,
    output logic            any,
    output logic [IDX_W-1:0] win
);

    logic [PW-1:0] best;

    // Ascending scan with <= lets the highest index win a tie
    always_comb begin
        best = '1;
        win  = '0;
        any  = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (elig[i] && (!any || prio_flat[i*PW +: PW] <= best)) begin
                best = prio_flat[i*PW +: PW];
                win  = IDX_W'(i);
                any  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/bic_top.sv
module bic_top
    import bic_pkg::*;
#(
    parameter int NBANKS = 2,
    localparam int NLINES = NBANKS * LINES_PER_BANK,
    localparam int IDX_W  = $clog2(NLINES),
    localparam int BANK_W = (NBANKS > 1) ? $clog2(NBANKS) : 1,
    localparam int ADDR_W = BANK_W + 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NLINES-1:0] irq_in,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_norm_o,
    output logic              irq_fast_o
);

    logic [BANK_W-1:0]          bank_idx;
    logic [7:0]                 off;
    logic                       bank0, bank_ok, ctrl_wr;
    logic [NLINES-1:0]          pend_all, mask_all, fast_all, clr_all;
    logic [NLINES*PRIO_W-1:0]   prio_all;
    logic [DATA_W-1:0]          brd [NBANKS];
    logic [NLINES-1:0]          elig [2];
    logic                       any_w [2];
    logic [IDX_W-1:0]           win_w [2];
    logic                       code_rd [2];
    agr_t                       agr_q [2];
    logic [IDX_W-1:0]           code_q [2];

    assign bank_idx = addr[ADDR_W-1:8];
    assign off      = addr[7:0];
    assign bank0    = (bank_idx == '0);
    assign bank_ok  = (int'(bank_idx) < NBANKS);
    assign ctrl_wr  = wr_en && bank0 && (off == OFF_CTRL);

    genvar b, o;
    generate
        for (b = 0; b < NBANKS; b++) begin : gen_bank
            bic_bank u_bank (
                .clk       (clk),
                .rst       (rst),
                .irq_in    (irq_in[b*LINES_PER_BANK +: LINES_PER_BANK]),
                .wr_en     (wr_en && (int'(bank_idx) == b)),
                .off       (off),
                .wdata     (wdata),
                .clr_vec   (clr_all[b*LINES_PER_BANK +: LINES_PER_BANK]),
                .pend      (pend_all[b*LINES_PER_BANK +: LINES_PER_BANK]),
                .mask      (mask_all[b*LINES_PER_BANK +: LINES_PER_BANK]),
                .fast      (fast_all[b*LINES_PER_BANK +: LINES_PER_BANK]),
                .prio_flat (prio_all[b*LINES_PER_BANK*PRIO_W +: LINES_PER_BANK*PRIO_W]),
                .rdata_loc (brd[b])
            );
        end
    endgenerate

    assign elig[0] = pend_all & ~mask_all & ~fast_all;
    assign elig[1] = pend_all & ~mask_all &  fast_all;
    assign code_rd[0] = rd_en && bank0 && (off == OFF_CODE_N);
    assign code_rd[1] = rd_en && bank0 && (off == OFF_CODE_F);

    generate
        for (o = 0; o < 2; o++) begin : gen_out
            bic_arbiter #(.N(NLINES), .PW(PRIO_W)) u_arb (
                .elig      (elig[o]),
                .prio_flat (prio_all),
                .any       (any_w[o]),
                .win       (win_w[o])
            );

            always_ff @(posedge clk) begin
                if (rst) begin
                    agr_q[o]  <= '{armed: 1'b1, active: 1'b0, seen: 1'b0};
                    code_q[o] <= '0;
                end else if (ctrl_wr && wdata[o]) begin
                    agr_q[o].active <= 1'b0;
                    agr_q[o].armed  <= 1'b1;
                end else if (agr_q[o].armed && any_w[o]) begin
                    agr_q[o]  <= '{armed: 1'b0, active: 1'b1, seen: 1'b1};
                    code_q[o] <= win_w[o];
                end
            end

            // R9: a raised output stays raised until its control bit is written
            a_r9_hold: assert property (@(posedge clk) disable iff (rst)
                (agr_q[o].active && !(ctrl_wr && wdata[o])) |=> agr_q[o].active);

            // R9: the captured code does not move while the output is high
            a_r9_frozen: assert property (@(posedge clk) disable iff (rst)
                agr_q[o].active |=> $stable(code_q[o]));

            // R7: an output only rises when a line was eligible the cycle before
            a_r7_rise_elig: assert property (@(posedge clk) disable iff (rst)
                $rose(agr_q[o].active) |-> $past(any_w[o]));

            // R8: the arbiter never names a line that is not eligible
            a_r8_win_elig: assert property (@(posedge clk) disable iff (rst)
                any_w[o] |-> elig[o][win_w[o]]);
        end
    endgenerate

    // R1: both outputs are low right after reset
    a_r1_reset_low: assert property (@(posedge clk)
        $past(rst) |-> (!agr_q[0].active && !agr_q[1].active));

    // Edge winners retire on a code read, but only after a real capture (R10, R12)
    always_comb begin
        clr_all = '0;
        for (int k = 0; k < 2; k++) begin
            if (code_rd[k] && agr_q[k].seen) clr_all[code_q[k]] = 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en && bank_ok) begin
            if (bank0 && off == OFF_CODE_N)
                rdata = {{(DATA_W-5){1'b0}}, code_q[0][4:0]};
            else if (bank0 && off == OFF_CODE_F)
                rdata = {{(DATA_W-5){1'b0}}, code_q[1][4:0]};
            else
                rdata = brd[bank_idx];
        end
    end

    assign irq_norm_o = agr_q[0].active;
    assign irq_fast_o = agr_q[1].active;

endmodule

// File: tb/bic_top_tb_top.sv
module bic_top_tb_top;

    localparam int NB     = 2;
    localparam int NL     = NB * 32;
    localparam int ADDR_W = 9;

    logic              clk = 1'b0;
    logic              rst;
    logic [NL-1:0]     irq_in;
    logic [ADDR_W-1:0] addr;
    logic [31:0]       wdata;
    logic              wr_en, rd_en;
    logic [31:0]       rdata;
    logic              irq_norm_o, irq_fast_o;

    int checks = 0;
    int errors = 0;
    logic [4:0] prio_m [NL];
    logic       route_m [NL];

    always #5 clk = ~clk;

    bic_top #(.NBANKS(NB)) dut_i (
        .clk(clk), .rst(rst), .irq_in(irq_in), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
        .irq_norm_o(irq_norm_o), .irq_fast_o(irq_fast_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input int bank, input int off, input logic [31:0] d);
        @(negedge clk);
        addr = ADDR_W'(bank * 256 + off); wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input int bank, input int off, output logic [31:0] d);
        @(negedge clk);
        addr = ADDR_W'(bank * 256 + off); rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic [NL-1:0] pat);
        @(negedge clk); irq_in = pat;
        @(negedge clk); irq_in = '0;
    endtask

    // Lowest priority value first, then the highest global number
    function automatic int pick(input logic [NL-1:0] e);
        int best = 32;
        for (int i = 0; i < NL; i++) if (e[i] && int'(prio_m[i]) < best) best = int'(prio_m[i]);
        for (int i = NL - 1; i >= 0; i--) if (e[i] && int'(prio_m[i]) == best) return i;
        return -1;
    endfunction

    initial begin
        #(1_000_000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [NL-1:0] pat, mk, en, ef;
        int wn, wf;
        irq_in = '0; addr = '0; wdata = '0; wr_en = 1'b0; rd_en = 1'b0;
        rst = 1'b1;
        idle(3);
        rst = 1'b0;

        // R1 reset state
        do_read(0, 'h04, d); check("R1 mask bank0", d, 32'hFFFF_FFFF);
        do_read(1, 'h04, d); check("R1 mask bank1", d, 32'hFFFF_FFFF);
        do_read(1, 'h00, d); check("R1 pending bank1", d, 0);
        do_read(0, 'h1C + 4*5, d); check("R1 line word", d, 0);
        check("R1 outputs low", {30'd0, irq_fast_o, irq_norm_o}, 0);
        // R12 code read before any capture
        do_read(0, 'h14, d); check("R12 fast code before capture", d, 0);
        do_read(0, 'h10, d); check("R12 normal code before capture", d, 0);

        // R3 packing
        do_write(1, 'h1C + 4*7, 32'hFFFF_FFFF);
        do_read(1, 'h1C + 4*7, d); check("R3 line word readback", d, 32'h7F);
        do_write(1, 'h1C + 4*7, 32'h0);

        // R2 unmapped / write-only / control reads
        do_read(0, 'h08, d); check("R2 unmapped 0x08", d, 0);
        do_read(1, 'hA0, d); check("R2 unmapped 0xA0", d, 0);
        do_read(0, 'h18, d); check("R2 control reads zero", d, 0);

        // R4 edge behaviour on bank0 line 3
        @(negedge clk); irq_in[3] = 1'b1;
        idle(2);
        do_read(0, 'h00, d); check("R4 edge sets pending", d, 32'h8);
        @(negedge clk); irq_in[3] = 1'b0;
        idle(2);
        do_read(0, 'h00, d); check("R4 edge survives drop", d, 32'h8);
        @(negedge clk); irq_in[3] = 1'b1;
        do_write(0, 'h00, 32'h0);
        idle(2);
        do_read(0, 'h00, d); check("R6 R4 cleared, held input no re-set", d, 0);
        @(negedge clk); irq_in[3] = 1'b0;

        // R5/R6 level behaviour on bank0 line 4
        do_write(0, 'h1C + 4*4, 32'h2);
        @(negedge clk); irq_in[4] = 1'b1;
        idle(2);
        do_read(0, 'h00, d); check("R5 level sets pending", d, 32'h10);
        do_write(0, 'h00, 32'h0);
        idle(1);
        do_read(0, 'h00, d); check("R6 level keeps pending under clear", d, 32'h10);
        @(negedge clk); irq_in[4] = 1'b0;
        idle(2);
        do_read(0, 'h00, d); check("R5 level clears on drop", d, 0);
        do_write(0, 'h1C + 4*4, 32'h0);

        // R11 software set raises lowest bit only
        do_write(1, 'h9C, 32'h0000_0C00);
        do_read(1, 'h00, d); check("R11 lowest bit only", d, 32'h400);
        do_read(1, 'h9C, d); check("R2 software-set reads zero", d, 0);
        do_write(1, 'h00, 32'h0);

        // R7/R8/R9/R10 normal output flow
        do_write(0, 'h1C + 4*2, 32'd3 << 2);
        do_write(1, 'h1C + 4*5, 32'd3 << 2);
        do_write(0, 'h1C + 4*6, 32'd0);
        do_write(0, 'h04, 32'h0);
        do_write(1, 'h04, 32'h0);
        pat = '0; pat[2] = 1'b1; pat[37] = 1'b1;
        pulse(pat);
        check("R7 output not yet high", {31'd0, irq_norm_o}, 0);
        idle(1);
        check("R7 output rises", {31'd0, irq_norm_o}, 1);
        pat = '0; pat[6] = 1'b1;
        pulse(pat);
        idle(2);
        do_read(0, 'h10, d); check("R8 R9 tie to higher global, frozen", d, 5);
        do_read(1, 'h00, d); check("R10 edge winner retired", d, 0);
        do_read(0, 'h00, d); check("R10 other pendings intact", d, 32'h44);
        do_write(1, 'h18, 32'h3);
        idle(2);
        check("R12 bank1 control ignored", {31'd0, irq_norm_o}, 1);
        do_write(0, 'h18, 32'h1);
        check("R9 control write lowers output", {31'd0, irq_norm_o}, 0);
        idle(1);
        check("R9 re-armed output rises", {31'd0, irq_norm_o}, 1);
        do_read(0, 'h10, d); check("R8 most urgent wins", d, 6);

        // R10 fast output with a level winner
        do_write(0, 'h1C + 4*9, (32'd2 << 2) | 32'h3);
        @(negedge clk); irq_in[9] = 1'b1;
        idle(3);
        check("R7 fast output rises", {31'd0, irq_fast_o}, 1);
        do_read(0, 'h14, d); check("R10 fast code", d, 9);
        do_read(0, 'h00, d); check("R10 level winner kept", d & 32'h200, 32'h200);
        @(negedge clk); irq_in[9] = 1'b0;

        // Random trials: R7 R8 R10 against the bench model
        void'($urandom(32'd12345));
        for (int t = 0; t < 20; t++) begin
            for (int l = 0; l < NL; l++) begin
                prio_m[l]  = 5'($urandom_range(0, 3));
                route_m[l] = 1'($urandom_range(0, 1));
                do_write(l / 32, 'h1C + 4*(l % 32), {25'd0, prio_m[l], 1'b0, route_m[l]});
            end
            mk  = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            pat = {$urandom, $urandom};
            do_write(0, 'h04, mk[31:0]);
            do_write(1, 'h04, mk[63:32]);
            do_write(0, 'h00, 32'h0);
            do_write(1, 'h00, 32'h0);
            do_write(0, 'h18, 32'h3);
            pulse(pat);
            idle(2);
            en = '0; ef = '0;
            for (int l = 0; l < NL; l++) begin
                en[l] = pat[l] & ~mk[l] & ~route_m[l];
                ef[l] = pat[l] & ~mk[l] &  route_m[l];
            end
            wn = pick(en); wf = pick(ef);
            check("R7 random normal level", {31'd0, irq_norm_o}, {31'd0, wn >= 0});
            check("R7 random fast level", {31'd0, irq_fast_o}, {31'd0, wf >= 0});
            if (wn >= 0) begin
                do_read(0, 'h10, d); check("R8 R10 random normal code", d, 32'(wn % 32));
            end
            if (wf >= 0) begin
                do_read(0, 'h14, d); check("R8 R10 random fast code", d, 32'(wf % 32));
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule